// File: doc/BRIEF.md
# Sharing-List Coherence Node Controller

This block tracks one cache line for one node of a directory-based distributed shared memory machine. The sharers of the line form a linked list, and each node keeps a forward pointer to the next sharer. The controller takes read and write requests from the local processor side. It talks to the home directory through a simple request/response port pair. It also exchanges invalidations, acknowledgements and busy replies with other nodes over a message port.

Races are kept out of the protocol in two ways. First, each node runs at most one transaction at a time, and it is atomic. While a miss is waiting for its data, or while an invalidation walk is under way, any invalidation from another node gets a busy reply. That node must retry, and the local line state is left untouched. This covers the case where the data reply is delayed behind an invalidation. Second, only the list head may write. A head that writes updates its copy at once and then invalidates the other sharers one at a time, following their forward pointers. A node that is not the head must first become head through the directory before it writes.

Top module: `slist_node_ctrl`

## Requirements
- R1: After reset the line state is INVALID (code 0), the forward pointer is all-ones, no output valid or done strobe is high, and the local request port is ready.
- R2: A local read (write=0) in INVALID moves the state to PENDING_READ (1) and issues a memory request with write=0 in the following cycle. A data reply (busy=0) then sets the state to SHARED_HEAD (3) if the reply's head flag is 1, otherwise to SHARED_MID (4). It also loads the forward pointer from the reply and raises done one cycle later.
- R3: An invalidation message (kind 0) that arrives while a transaction is open (PENDING_READ, PENDING_WRITE or a walk in progress) is answered one cycle later with a busy reply (busy=1) addressed to its source. Line state and forward pointer are unchanged.
- R4: An invalidation that arrives while no transaction is open is answered one cycle later with an acknowledgement (busy=0) carrying the node's forward pointer. The state becomes INVALID and the pointer all-ones.
- R5: When an invalidation arrives in the same cycle as a local request, the request port is not ready in that cycle, and the invalidation is served first.
- R6: A local request is accepted only when no transaction is open. Reads in states 3, 4 and 5 and writes in MODIFIED_HEAD (5) complete with done one cycle later, with no memory request.
- R7: A write in INVALID or SHARED_MID goes to PENDING_WRITE (2) with a memory request of write=1. Its data reply makes the node head in MODIFIED_HEAD (5) and starts the walk from the reply's pointer.
- R8: A write in SHARED_HEAD changes the state to MODIFIED_HEAD and the pointer to all-ones in the next cycle, and starts the walk from the old pointer.
- R9: The walk sends one invalidation at a time, and only in MODIFIED_HEAD. The next one goes out the cycle after an acknowledgement (kind 1) from the current target, to the pointer that acknowledgement carries. The walk ends at all-ones.
- R10: Done for a write that needs a walk is raised only in the cycle after the last acknowledgement. If the list is empty, done is raised in the cycle after the walk would start.
- R11: After a busy response (memory busy=1, or message kind 2 from the current walk target), the same request is re-sent exactly B+2 cycles after the busy cycle, where B is the backoff setting.
- R12: Acknowledgements or busy messages that are not from the current walk target, and memory responses when nothing is pending, change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_backoff | input | BACKOFF_W | Retry wait setting B |
| loc_req_valid | input | 1 | Local request present |
| loc_req_write | input | 1 | 1 = write, 0 = read |
| loc_req_ready | output | 1 | Local request accepted this cycle if valid |
| loc_done | output | 1 | One-cycle completion strobe |
| mem_req_valid | output | 1 | Request to home directory |
| mem_req_write | output | 1 | 1 = become head for write, 0 = join for read |
| mem_rsp_valid | input | 1 | Directory response present |
| mem_rsp_busy | input | 1 | Directory says retry |
| mem_rsp_head | input | 1 | Read reply places node at the head |
| mem_rsp_fwd | input | NODE_W | Next sharer after this node |
| net_in_valid | input | 1 | Incoming node message present |
| net_in_kind | input | 2 | 0 invalidate, 1 acknowledge, 2 busy |
| net_in_src | input | NODE_W | Sending node |
| net_in_fwd | input | NODE_W | Sender's forward pointer (acknowledge) |
| inv_out_valid | output | 1 | Outgoing invalidation |
| inv_out_dst | output | NODE_W | Invalidation target |
| rep_out_valid | output | 1 | Outgoing reply to a foreign invalidation |
| rep_out_busy | output | 1 | 1 = busy/retry, 0 = acknowledge |
| rep_out_dst | output | NODE_W | Reply target |
| rep_out_fwd | output | NODE_W | Forward pointer handed over with an acknowledge |
| line_state | output | 3 | Local line state code |
| fwd_ptr | output | NODE_W | Current forward pointer |

## Verification
A foreign invalidation can coincide with two other events: a local request being presented, and the delayed data reply of a pending read. The bench drives the invalidation together with a local request and checks that ready is low and that the reply is an acknowledgement. It also replays the early-invalidation order: the invalidation comes first and must get a busy reply with the pending state held, then the data reply arrives, and then the retried invalidation is acknowledged with the new pointer. The walks use random list lengths, random busy responses and random intruding messages. They are judged against gaps and targets computed in the bench.

// File: rtl/slist_pkg.sv
package slist_pkg;
  typedef enum logic [2:0] {
    LS_INVALID  = 3'd0,
    LS_PEND_RD  = 3'd1,
    LS_PEND_WR  = 3'd2,
    LS_SH_HEAD  = 3'd3,
    LS_SH_MID   = 3'd4,
    LS_MOD_HEAD = 3'd5
  } line_st_e;

  typedef enum logic [1:0] {
    MSG_INV  = 2'd0,
    MSG_ACK  = 2'd1,
    MSG_BUSY = 2'd2
  } msg_e;
endpackage

// File: rtl/slist_backoff.sv
module slist_backoff #(
  parameter int BACKOFF_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [BACKOFF_W-1:0] load_val,
  output logic                 fire
);
  logic [BACKOFF_W-1:0] cnt_q;
  logic                 wait_q;

  assign fire = wait_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wait_q <= 1'b0;
    end else if (start) begin
      cnt_q  <= load_val;
      wait_q <= 1'b1;
    end else if (fire) begin
      wait_q <= 1'b0;
    end else if (wait_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/slist_inv_walk.sv
module slist_inv_walk #(
  parameter int NODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [NODE_W-1:0] start_ptr,
  input  logic              ack_v,
  input  logic              busy_v,
  input  logic [NODE_W-1:0] msg_src,
  input  logic [NODE_W-1:0] msg_fwd,
  input  logic              retry_fire,
  output logic              inv_v,
  output logic [NODE_W-1:0] inv_dst,
  output logic              active,
  output logic              done,
  output logic              busy_hit
);
  function automatic logic ptr_is_end(input logic [NODE_W-1:0] p);
    return &p;
  endfunction

  logic              active_q, inv_q, done_q;
  logic [NODE_W-1:0] target_q;
  logic              from_target, ack_hit;

  assign from_target = active_q && (msg_src == target_q);
  assign ack_hit     = ack_v && from_target;
  assign busy_hit    = busy_v && from_target;
  assign inv_v       = inv_q;
  assign inv_dst     = target_q;
  assign active      = active_q;
  assign done        = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      inv_q    <= 1'b0;
      done_q   <= 1'b0;
      target_q <= '1;
    end else begin
      inv_q  <= 1'b0;
      done_q <= 1'b0;
      if (start) begin
        if (ptr_is_end(start_ptr)) begin
          done_q <= 1'b1;
        end else begin
          active_q <= 1'b1;
          target_q <= start_ptr;
          inv_q    <= 1'b1;
        end
      end else if (ack_hit) begin
        if (ptr_is_end(msg_fwd)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end else begin
          target_q <= msg_fwd;
          inv_q    <= 1'b1;
        end
      end else if (retry_fire && active_q) begin
        inv_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/slist_node_ctrl.sv
module slist_node_ctrl
  import slist_pkg::*;
#(
  parameter int NODE_W    = 4,
  parameter int BACKOFF_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BACKOFF_W-1:0] cfg_backoff,
  input  logic                 loc_req_valid,
  input  logic                 loc_req_write,
  output logic                 loc_req_ready,
  output logic                 loc_done,
  output logic                 mem_req_valid,
  output logic                 mem_req_write,
  input  logic                 mem_rsp_valid,
  input  logic                 mem_rsp_busy,
  input  logic                 mem_rsp_head,
  input  logic [NODE_W-1:0]    mem_rsp_fwd,
  input  logic                 net_in_valid,
  input  logic [1:0]           net_in_kind,
  input  logic [NODE_W-1:0]    net_in_src,
  input  logic [NODE_W-1:0]    net_in_fwd,
  output logic                 inv_out_valid,
  output logic [NODE_W-1:0]    inv_out_dst,
  output logic                 rep_out_valid,
  output logic                 rep_out_busy,
  output logic [NODE_W-1:0]    rep_out_dst,
  output logic [NODE_W-1:0]    rep_out_fwd,
  output logic [2:0]           line_state,
  output logic [NODE_W-1:0]    fwd_ptr
);
  localparam logic [NODE_W-1:0] END_PTR = '1;

  line_st_e          state_q;
  logic [NODE_W-1:0] fwd_q, rep_dst_q, rep_fwd_q;
  logic              done_q, mreq_q, mreq_w_q, rep_v_q, rep_b_q;

  // named events for the checker
  logic              foreign_inv, pending, walk_active, txn_open, accept;
  logic              rsp_data, rsp_busy, head_wr, walk_start, walk_done;
  logic              walk_busy_hit, retry_fire, bo_start, mem_retry;
  logic              net_ack, net_busy;
  logic [NODE_W-1:0] walk_ptr;

  assign foreign_inv = net_in_valid && (net_in_kind == MSG_INV);
  assign net_ack     = net_in_valid && (net_in_kind == MSG_ACK);
  assign net_busy    = net_in_valid && (net_in_kind == MSG_BUSY);
  assign pending     = (state_q == LS_PEND_RD) || (state_q == LS_PEND_WR);
  assign txn_open    = pending || walk_active;
  assign loc_req_ready = !txn_open && !foreign_inv;
  assign accept      = loc_req_valid && loc_req_ready;
  assign rsp_data    = mem_rsp_valid && !mem_rsp_busy && pending;
  assign rsp_busy    = mem_rsp_valid && mem_rsp_busy && pending;
  assign head_wr     = accept && loc_req_write && (state_q == LS_SH_HEAD);
  assign walk_start  = head_wr || (rsp_data && (state_q == LS_PEND_WR));
  assign walk_ptr    = head_wr ? fwd_q : mem_rsp_fwd;
  assign bo_start    = rsp_busy || walk_busy_hit;
  assign mem_retry   = retry_fire && pending;

  slist_backoff #(.BACKOFF_W(BACKOFF_W)) u_backoff (
    .clk(clk), .rst_n(rst_n), .start(bo_start), .load_val(cfg_backoff),
    .fire(retry_fire)
  );

  slist_inv_walk #(.NODE_W(NODE_W)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(walk_start), .start_ptr(walk_ptr),
    .ack_v(net_ack), .busy_v(net_busy), .msg_src(net_in_src),
    .msg_fwd(net_in_fwd), .retry_fire(retry_fire),
    .inv_v(inv_out_valid), .inv_dst(inv_out_dst), .active(walk_active),
    .done(walk_done), .busy_hit(walk_busy_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= LS_INVALID;
      fwd_q     <= END_PTR;
      done_q    <= 1'b0;
      mreq_q    <= 1'b0;
      mreq_w_q  <= 1'b0;
      rep_v_q   <= 1'b0;
      rep_b_q   <= 1'b0;
      rep_dst_q <= '0;
      rep_fwd_q <= END_PTR;
    end else begin
      done_q  <= 1'b0;
      mreq_q  <= 1'b0;
      rep_v_q <= 1'b0;
      if (foreign_inv) begin
        rep_v_q   <= 1'b1;
        rep_dst_q <= net_in_src;
        rep_b_q   <= txn_open;
        rep_fwd_q <= txn_open ? END_PTR : fwd_q;
        if (!txn_open) begin
          state_q <= LS_INVALID;
          fwd_q   <= END_PTR;
        end
      end
      if (accept) begin
        case (state_q)
          LS_INVALID: begin
            state_q  <= loc_req_write ? LS_PEND_WR : LS_PEND_RD;
            mreq_q   <= 1'b1;
            mreq_w_q <= loc_req_write;
          end
          LS_SH_HEAD: begin
            if (loc_req_write) begin
              state_q <= LS_MOD_HEAD;
              fwd_q   <= END_PTR;
            end else begin
              done_q <= 1'b1;
            end
          end
          LS_SH_MID: begin
            if (loc_req_write) begin
              state_q  <= LS_PEND_WR;
              mreq_q   <= 1'b1;
              mreq_w_q <= 1'b1;
            end else begin
              done_q <= 1'b1;
            end
          end
          LS_MOD_HEAD: done_q <= 1'b1;
          default: ;
        endcase
      end
      if (rsp_data) begin
        if (state_q == LS_PEND_RD) begin
          state_q <= mem_rsp_head ? LS_SH_HEAD : LS_SH_MID;
          fwd_q   <= mem_rsp_fwd;
          done_q  <= 1'b1;
        end else begin
          state_q <= LS_MOD_HEAD;
          fwd_q   <= END_PTR;
        end
      end
      if (mem_retry) begin
        mreq_q   <= 1'b1;
        mreq_w_q <= (state_q == LS_PEND_WR);
      end
    end
  end

  assign loc_done      = done_q || walk_done;
  assign mem_req_valid = mreq_q;
  assign mem_req_write = mreq_w_q;
  assign rep_out_valid = rep_v_q;
  assign rep_out_busy  = rep_b_q;
  assign rep_out_dst   = rep_dst_q;
  assign rep_out_fwd   = rep_fwd_q;
  assign line_state    = state_q;
  assign fwd_ptr       = fwd_q;
endmodule

// File: rtl/slist_node_chk.sv
module slist_node_chk
  import slist_pkg::*;
#(
  parameter int NODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        line_state,
  input logic [NODE_W-1:0] fwd_ptr,
  input logic              txn_open,
  input logic              foreign_inv,
  input logic              walk_active,
  input logic              loc_req_ready,
  input logic              loc_done,
  input logic              mem_req_valid,
  input logic              mem_rsp_valid,
  input logic              inv_out_valid,
  input logic              rep_out_valid,
  input logic              rep_out_busy
);
  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    txn_open && foreign_inv && !mem_rsp_valid |=>
      rep_out_valid && rep_out_busy && $stable(line_state) && $stable(fwd_ptr));

  p_idle_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_open && foreign_inv |=>
      rep_out_valid && !rep_out_busy && line_state == LS_INVALID && (&fwd_ptr));

  p_inv_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    foreign_inv |-> !loc_req_ready);

  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loc_req_ready |-> line_state != LS_PEND_RD && line_state != LS_PEND_WR && !inv_out_valid);

  p_memreq_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> line_state == LS_PEND_RD || line_state == LS_PEND_WR);

  p_inv_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_out_valid |-> line_state == LS_MOD_HEAD && walk_active);

  p_inv_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inv_out_valid |=> !inv_out_valid);

  p_done_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_done |-> !walk_active && line_state != LS_PEND_RD && line_state != LS_PEND_WR);
endmodule

bind slist_node_ctrl slist_node_chk #(.NODE_W(NODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_state(line_state), .fwd_ptr(fwd_ptr),
  .txn_open(txn_open), .foreign_inv(foreign_inv), .walk_active(walk_active),
  .loc_req_ready(loc_req_ready), .loc_done(loc_done),
  .mem_req_valid(mem_req_valid), .mem_rsp_valid(mem_rsp_valid),
  .inv_out_valid(inv_out_valid), .rep_out_valid(rep_out_valid),
  .rep_out_busy(rep_out_busy)
);

// File: tb/slist_node_ctrl_test.sv
`timescale 1ns/1ps
module slist_node_ctrl_test;
  localparam int NW = 4;
  localparam int BW = 4;
  localparam logic [NW-1:0] NIL = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [BW-1:0] cfg_backoff = '0;
  logic loc_req_valid = 0, loc_req_write = 0, loc_req_ready, loc_done;
  logic mem_req_valid, mem_req_write;
  logic mem_rsp_valid = 0, mem_rsp_busy = 0, mem_rsp_head = 0;
  logic [NW-1:0] mem_rsp_fwd = '0;
  logic net_in_valid = 0;
  logic [1:0] net_in_kind = '0;
  logic [NW-1:0] net_in_src = '0, net_in_fwd = '0;
  logic inv_out_valid, rep_out_valid, rep_out_busy;
  logic [NW-1:0] inv_out_dst, rep_out_dst, rep_out_fwd, fwd_ptr;
  logic [2:0] line_state;

  always #2.5 clk = ~clk;

  slist_node_ctrl #(.NODE_W(NW), .BACKOFF_W(BW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_backoff(cfg_backoff),
    .loc_req_valid(loc_req_valid), .loc_req_write(loc_req_write),
    .loc_req_ready(loc_req_ready), .loc_done(loc_done),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_busy(mem_rsp_busy),
    .mem_rsp_head(mem_rsp_head), .mem_rsp_fwd(mem_rsp_fwd),
    .net_in_valid(net_in_valid), .net_in_kind(net_in_kind),
    .net_in_src(net_in_src), .net_in_fwd(net_in_fwd),
    .inv_out_valid(inv_out_valid), .inv_out_dst(inv_out_dst),
    .rep_out_valid(rep_out_valid), .rep_out_busy(rep_out_busy),
    .rep_out_dst(rep_out_dst), .rep_out_fwd(rep_out_fwd),
    .line_state(line_state), .fwd_ptr(fwd_ptr)
  );

  int nchk = 0, nbad = 0;

  function automatic int exp_gap(input int b);
    return b + 2;
  endfunction

  function automatic int exp_fill(input bit head);
    return head ? 3 : 4;
  endfunction

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic eq(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic net(input logic [1:0] k, input logic [NW-1:0] s, input logic [NW-1:0] f);
    net_in_valid = 1; net_in_kind = k; net_in_src = s; net_in_fwd = f;
    tick;
    net_in_valid = 0;
  endtask

  task automatic mrsp(input bit b, input bit h, input logic [NW-1:0] f);
    mem_rsp_valid = 1; mem_rsp_busy = b; mem_rsp_head = h; mem_rsp_fwd = f;
    tick;
    mem_rsp_valid = 0;
  endtask

  task automatic loc(input bit w);
    loc_req_valid = 1; loc_req_write = w;
    #1 eq("R6 ready when idle", loc_req_ready, 1);
    tick;
    loc_req_valid = 0;
  endtask

  task automatic mem_retry_maybe(input bit w);
    int n;
    if ($urandom % 2 == 1) begin
      mrsp(1, 0, '0);
      n = 1;
      while (!mem_req_valid && n < 64) begin tick; n++; end
      eq("R11 memory retry gap", n, exp_gap(cfg_backoff));
      eq("R11 memory retry kind", mem_req_write, w);
    end
  endtask

  task automatic make_invalid;
    if (line_state != 3'd0) begin
      net(2'd0, 4'd12, '0);
      eq("R4 idle inv ack", rep_out_busy, 0);
      eq("R4 idle inv state", line_state, 0);
    end
  endtask

  task automatic go_shared(input bit h, input logic [NW-1:0] f);
    loc(0);
    eq("R2 pending read", line_state, 1);
    eq("R2 read request", mem_req_valid, 1);
    eq("R2 read kind", mem_req_write, 0);
    mem_retry_maybe(0);
    mrsp(0, h, f);
    eq("R2 filled state", line_state, exp_fill(h));
    eq("R2 filled pointer", fwd_ptr, f);
    eq("R2 read done", loc_done, 1);
  endtask

  task automatic walk(input logic [NW-1:0] first, input int len);
    logic [NW-1:0] cur, nxt;
    cur = first;
    if (len == 0) begin
      eq("R10 empty list done", loc_done, 1);
      eq("R9 no inv for empty list", inv_out_valid, 0);
      return;
    end
    for (int i = 0; i < len; i++) begin
      eq("R9 inv sent", inv_out_valid, 1);
      eq("R9 inv target", inv_out_dst, cur);
      eq("R9 inv from modified head", line_state, 5);
      eq("R10 no early done", loc_done, 0);
      tick;
      if ($urandom % 3 == 0) begin
        int n;
        net(2'd2, cur, '0);
        n = 1;
        while (!inv_out_valid && n < 64) begin tick; n++; end
        eq("R11 inv retry gap", n, exp_gap(cfg_backoff));
        eq("R11 inv retry target", inv_out_dst, cur);
        tick;
      end
      if ($urandom % 3 == 0) begin
        net(2'd1, cur ^ 4'd1, '0);
        eq("R12 stray ack no inv", inv_out_valid, 0);
        eq("R12 stray ack no done", loc_done, 0);
      end
      if ($urandom % 3 == 0) begin
        net(2'd0, 4'd13, '0);
        eq("R3 busy during walk", rep_out_busy, 1);
        eq("R3 busy reply valid", rep_out_valid, 1);
        eq("R3 busy reply target", rep_out_dst, 13);
        eq("R3 walk state held", line_state, 5);
      end
      nxt = (i == len - 1) ? NIL : NW'($urandom % 15);
      net(2'd1, cur, nxt);
      cur = nxt;
    end
    eq("R10 done after last ack", loc_done, 1);
    eq("R9 walk ended", inv_out_valid, 0);
  endtask

  task automatic early_inv(input bit h, input logic [NW-1:0] f);
    loc(0);
    eq("R2 pending read", line_state, 1);
    net(2'd0, 4'd3, '0);
    eq("R3 early inv busy", rep_out_busy, 1);
    eq("R3 early inv reply valid", rep_out_valid, 1);
    eq("R3 early inv target", rep_out_dst, 3);
    eq("R3 early inv state held", line_state, 1);
    eq("R3 early inv pointer held", fwd_ptr, NIL);
    mem_retry_maybe(0);
    mrsp(0, h, f);
    eq("R2 delayed data state", line_state, exp_fill(h));
    net(2'd0, 4'd3, '0);
    eq("R4 retried inv ack", rep_out_busy, 0);
    eq("R4 retried inv pointer", rep_out_fwd, f);
    eq("R4 retried inv state", line_state, 0);
    eq("R4 retried inv clears ptr", fwd_ptr, NIL);
  endtask

  task automatic head_write(input int len);
    logic [NW-1:0] first;
    first = (len == 0) ? NIL : NW'($urandom % 15);
    go_shared(1, first);
    loc(1);
    eq("R8 head write state", line_state, 5);
    eq("R8 head write pointer", fwd_ptr, NIL);
    eq("R8 no memory request", mem_req_valid, 0);
    walk(first, len);
  endtask

  task automatic nonhead_write(input int len, input bit from_mid);
    logic [NW-1:0] first;
    first = (len == 0) ? NIL : NW'($urandom % 15);
    if (from_mid) go_shared(0, 4'd6);
    loc(1);
    eq("R7 pending write", line_state, 2);
    eq("R7 write request", mem_req_valid, 1);
    eq("R7 write kind", mem_req_write, 1);
    mem_retry_maybe(1);
    mrsp(0, 0, first);
    eq("R7 becomes head", line_state, 5);
    walk(first, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5061));
    repeat (3) tick;
    rst_n = 1;
    tick;
    eq("R1 reset state", line_state, 0);
    eq("R1 reset pointer", fwd_ptr, NIL);
    eq("R1 reset ready", loc_req_ready, 1);
    eq("R1 reset no outputs", {mem_req_valid, inv_out_valid, rep_out_valid, loc_done}, 0);

    cfg_backoff = 4'd3;
    early_inv(0, 4'd5);

    net(2'd1, 4'd2, '0);
    eq("R12 ack when idle no reply", rep_out_valid, 0);
    eq("R12 ack when idle state", line_state, 0);
    mrsp(0, 1, 4'd7);
    eq("R12 stray data state", line_state, 0);
    eq("R12 stray data no done", loc_done, 0);

    nonhead_write(3, 1);
    loc(1);
    eq("R6 write hit done", loc_done, 1);
    eq("R6 write hit no request", mem_req_valid, 0);
    loc(0);
    eq("R6 read hit done", loc_done, 1);

    net_in_valid = 1; net_in_kind = 2'd0; net_in_src = 4'd9; net_in_fwd = '0;
    loc_req_valid = 1; loc_req_write = 0;
    #1 eq("R5 not ready during inv", loc_req_ready, 0);
    tick;
    net_in_valid = 0; loc_req_valid = 0;
    eq("R5 inv served ack", rep_out_busy, 0);
    eq("R5 inv served target", rep_out_dst, 9);
    eq("R5 inv served state", line_state, 0);
    eq("R5 request not taken", mem_req_valid, 0);

    head_write(2);
    make_invalid;
    head_write(0);
    make_invalid;
    nonhead_write(0, 0);

    for (int r = 0; r < 40; r++) begin
      cfg_backoff = BW'($urandom % 6);
      make_invalid;
      case ($urandom % 3)
        0: head_write(int'($urandom % 5));
        1: nonhead_write(int'($urandom % 5), 1'($urandom % 2));
        default: early_inv(1'($urandom % 2), NW'($urandom % 16));
      endcase
    end

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule